// File: doc/BRIEF.md
# Slow-Clock System Watchdog with Sticky Reset Cause

This block is a system watchdog whose timeout counter runs from its own slow clock, independent of the bus clock used to program it. Software sets the action enables and a terminal-count period through one byte-wide control/status register, then writes a strobe bit at intervals shorter than the period. If the strobe stops, the watchdog raises a non-maskable interrupt, a system reset, or the interrupt followed by the reset, depending on the enables.

Status and control bits are cleared only by the power-on reset `rst_ni`. The system reset pulse the block produces leaves them unchanged. After a restart, software can read which action fired last. Strobe requests cross into the slow domain through a toggle synchroniser. Expiry events come back to the bus domain the same way, through a toggle and a synchroniser.

Top module: `wdt_sticky_top`

## Requirements
- R1: While `rst_ni` is low and after it rises, the register reads 0x00, and `nmi_o` and `sys_rst_o` are low.
- R2: A register write stores reset enable (bit 5), NMI enable (bit 4) and period select (bits 2:0), and these read back exactly as written. The strobe (bit 3) always reads 0.
- R3: Writes take effect only when `addr_i` equals the register address (default 0x79). Writes to any other address leave the register unchanged.
- R4: Writing 1 to the strobe bit restarts the count. Strobes spaced closer than the period keep the watchdog from expiring.
- R5: With only reset enabled, the last strobe is followed by `sys_rst_o` rising no sooner than 8<<sel slow ticks later and at most 6 ticks after that. Reset status (bit 7) is then set.
- R6: `sys_rst_o` stays high for exactly 4 slow-clock ticks per event.
- R7: The reset pulse changes neither the status bits nor the control bits.
- R8: Writing 1 to a status bit (bit 7 or bit 6) clears it. Writing 0 to it leaves it unchanged.
- R9: With only NMI enabled, an expiry sets NMI status (bit 6), `nmi_o` follows that bit, and no system reset occurs.
- R10: With both enables set, an expiry raises the NMI first. A system reset follows one full period (8<<sel ticks, within one tick) later if no strobe arrives.
- R11: While both enables are clear, the counter is held at zero and nothing ever expires.
- R12: Changing the period select restarts the count, and the new period applies from that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| slow_clk_i | input | 1 | Independent slow timeout clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | I/O address of the write |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Register contents |
| nmi_o | output | 1 | NMI request, level, equal to NMI status |
| sys_rst_o | output | 1 | System reset pulse, slow-clock domain |

## Verification
Several properties hold on every cycle and are checked as such. Writes to the decoded address land in the control fields, and other cycles leave those fields stable. A status bit falls only on a write of 1 to it. In the slow domain the counter stays at zero while both enables are clear, every reset pulse is four ticks long, and a reset under both enables is always preceded by an armed NMI. Timing and order across the two clock domains can only be shown by the bench's scenarios. These cover the minimum and maximum timeout after the last strobe, keepalive by periodic strobes, the NMI-to-reset gap, restart on a period change, and status surviving the reset pulse.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  localparam int RST_STS_BIT = 7;
  localparam int NMI_STS_BIT = 6;
  localparam int RST_EN_BIT  = 5;
  localparam int NMI_EN_BIT  = 4;
  localparam int STROBE_BIT  = 3;
  localparam int SEL_W       = 3;

  typedef struct packed {
    logic             rst_en;
    logic             nmi_en;
    logic [SEL_W-1:0] sel;
  } wdt_ctrl_t;

  localparam int CTRL_W = $bits(wdt_ctrl_t);
endpackage

// File: rtl/wdt_sync.sv
`timescale 1ns/1ps
module wdt_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= stg_q[g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/wdt_bus_regs.sv
`timescale 1ns/1ps
module wdt_bus_regs
  import wdt_pkg::*;
#(
  parameter logic [7:0] REG_ADDR    = 8'h79,
  parameter int         SYNC_STAGES = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_en_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wr_data_i,
  input  logic      nmi_tgl_i,
  input  logic      rst_tgl_i,
  output wdt_ctrl_t ctrl_o,
  output logic      strb_tgl_o,
  output logic [7:0] rd_data_o,
  output logic      nmi_sts_o
);
  wdt_ctrl_t  ctrl_q;
  logic       strb_tgl_q, rst_sts_q, nmi_sts_q;
  logic [1:0] ev_s, ev_q;
  logic       wr_hit, nmi_set, rst_set;

  wdt_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_ev_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({rst_tgl_i, nmi_tgl_i}),
    .q_o   (ev_s)
  );

  assign wr_hit  = wr_en_i && (addr_i == REG_ADDR);
  assign nmi_set = ev_s[0] ^ ev_q[0];
  assign rst_set = ev_s[1] ^ ev_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      strb_tgl_q <= 1'b0;
      rst_sts_q  <= 1'b0;
      nmi_sts_q  <= 1'b0;
      ev_q       <= '0;
    end else begin
      ev_q <= ev_s;
      if (wr_hit) begin
        ctrl_q.rst_en <= wr_data_i[RST_EN_BIT];
        ctrl_q.nmi_en <= wr_data_i[NMI_EN_BIT];
        ctrl_q.sel    <= wr_data_i[SEL_W-1:0];
        if (wr_data_i[STROBE_BIT]) strb_tgl_q <= ~strb_tgl_q;
      end
      // a new event wins over a simultaneous clear
      if (rst_set)                               rst_sts_q <= 1'b1;
      else if (wr_hit && wr_data_i[RST_STS_BIT]) rst_sts_q <= 1'b0;
      if (nmi_set)                               nmi_sts_q <= 1'b1;
      else if (wr_hit && wr_data_i[NMI_STS_BIT]) nmi_sts_q <= 1'b0;
    end
  end

  assign ctrl_o     = ctrl_q;
  assign strb_tgl_o = strb_tgl_q;
  assign nmi_sts_o  = nmi_sts_q;
  assign rd_data_o  = {rst_sts_q, nmi_sts_q, ctrl_q.rst_en, ctrl_q.nmi_en, 1'b0, ctrl_q.sel};

  p_ctrl_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit |=> (rd_data_o[5:0] == {$past(wr_data_i[5:4]), 1'b0, $past(wr_data_i[2:0])}));
  p_no_foreign_wr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit |=> $stable(rd_data_o[5:0]));
  p_rst_sts_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_data_o[RST_STS_BIT]) |-> $past(wr_hit && wr_data_i[RST_STS_BIT]));
  p_nmi_sts_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_data_o[NMI_STS_BIT]) |-> $past(wr_hit && wr_data_i[NMI_STS_BIT]));
endmodule

// File: rtl/wdt_slow_core.sv
`timescale 1ns/1ps
module wdt_slow_core
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2   = 3,
  parameter int RST_TICKS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic      slow_clk_i,
  input  logic      rst_ni,
  input  wdt_ctrl_t ctrl_i,
  input  logic      strb_tgl_i,
  output logic      nmi_tgl_o,
  output logic      rst_tgl_o,
  output logic      sys_rst_o
);
  localparam int CNT_W  = BASE_LOG2 + (1 << SEL_W) - 1;
  localparam int HOLD_W = $clog2(RST_TICKS + 1);

  wdt_ctrl_t            ctrl_s;
  logic                 strb_s, strb_q;
  logic [SEL_W-1:0]     sel_q;
  logic [CNT_W-1:0]     cnt_q, term_m1;
  logic [CNT_W:0]       term_full;
  logic [HOLD_W-1:0]    hold_q;
  logic                 nmi_armed_q, nmi_tgl_q, rst_tgl_q, sys_rst_q;
  logic                 any_en, both_en, restart;

  wdt_sync #(.WIDTH(CTRL_W + 1), .STAGES(SYNC_STAGES)) i_ctrl_sync (
    .clk_i (slow_clk_i),
    .rst_ni(rst_ni),
    .d_i   ({strb_tgl_i, ctrl_i}),
    .q_o   ({strb_s, ctrl_s})
  );

  assign any_en    = ctrl_s.rst_en | ctrl_s.nmi_en;
  assign both_en   = ctrl_s.rst_en & ctrl_s.nmi_en;
  // strobe pulse or a new period restarts the count
  assign restart   = (strb_s ^ strb_q) || (ctrl_s.sel != sel_q);
  assign term_full = ((CNT_W+1)'(1) << (BASE_LOG2 + int'(ctrl_s.sel))) - (CNT_W+1)'(1);
  assign term_m1   = term_full[CNT_W-1:0];

  always_ff @(posedge slow_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strb_q      <= 1'b0;
      sel_q       <= '0;
      cnt_q       <= '0;
      nmi_armed_q <= 1'b0;
      nmi_tgl_q   <= 1'b0;
      rst_tgl_q   <= 1'b0;
      sys_rst_q   <= 1'b0;
      hold_q      <= '0;
    end else begin
      strb_q <= strb_s;
      sel_q  <= ctrl_s.sel;
      if (hold_q != '0)   hold_q    <= hold_q - 1'b1;
      else if (sys_rst_q) sys_rst_q <= 1'b0;
      if (!any_en || restart) begin
        cnt_q       <= '0;
        nmi_armed_q <= 1'b0;
      end else if (cnt_q == term_m1) begin
        cnt_q <= '0;
        if (ctrl_s.rst_en && (!ctrl_s.nmi_en || nmi_armed_q)) begin
          rst_tgl_q   <= ~rst_tgl_q;
          sys_rst_q   <= 1'b1;
          hold_q      <= HOLD_W'(RST_TICKS - 1);
          nmi_armed_q <= 1'b0;
        end else begin
          nmi_tgl_q   <= ~nmi_tgl_q;
          nmi_armed_q <= both_en;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign nmi_tgl_o = nmi_tgl_q;
  assign rst_tgl_o = rst_tgl_q;
  assign sys_rst_o = sys_rst_q;

  // checker: length of each reset pulse
  logic [15:0] chk_len_q;
  always_ff @(posedge slow_clk_i or negedge rst_ni)
    if (!rst_ni)        chk_len_q <= '0;
    else if (sys_rst_q) chk_len_q <= (chk_len_q == 16'hffff) ? chk_len_q : chk_len_q + 1'b1;
    else                chk_len_q <= '0;

  p_rst_len_r6: assert property (@(posedge slow_clk_i) disable iff (!rst_ni)
    $fell(sys_rst_q) |-> (chk_len_q == 16'(RST_TICKS)));
  p_hold_idle_r11: assert property (@(posedge slow_clk_i) disable iff (!rst_ni)
    !any_en |=> (cnt_q == '0 && !$rose(sys_rst_q)));
  p_rst_needs_en_r5: assert property (@(posedge slow_clk_i) disable iff (!rst_ni)
    $rose(sys_rst_q) |-> $past(ctrl_s.rst_en));
  p_nmi_before_rst_r10: assert property (@(posedge slow_clk_i) disable iff (!rst_ni)
    ($rose(sys_rst_q) && $past(ctrl_s.nmi_en)) |-> $past(nmi_armed_q));
endmodule

// File: rtl/wdt_sticky_top.sv
`timescale 1ns/1ps
module wdt_sticky_top
  import wdt_pkg::*;
#(
  parameter logic [7:0] REG_ADDR    = 8'h79,
  parameter int         BASE_LOG2   = 3,
  parameter int         RST_TICKS   = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       slow_clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  output logic       nmi_o,
  output logic       sys_rst_o
);
  wdt_ctrl_t ctrl;
  logic      strb_tgl, nmi_tgl, rst_tgl;

  wdt_bus_regs #(.REG_ADDR(REG_ADDR), .SYNC_STAGES(SYNC_STAGES)) i_bus_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wr_data_i (wr_data_i),
    .nmi_tgl_i (nmi_tgl),
    .rst_tgl_i (rst_tgl),
    .ctrl_o    (ctrl),
    .strb_tgl_o(strb_tgl),
    .rd_data_o (rd_data_o),
    .nmi_sts_o (nmi_o)
  );

  wdt_slow_core #(.BASE_LOG2(BASE_LOG2), .RST_TICKS(RST_TICKS), .SYNC_STAGES(SYNC_STAGES)) i_slow_core (
    .slow_clk_i(slow_clk_i),
    .rst_ni    (rst_ni),
    .ctrl_i    (ctrl),
    .strb_tgl_i(strb_tgl),
    .nmi_tgl_o (nmi_tgl),
    .rst_tgl_o (rst_tgl),
    .sys_rst_o (sys_rst_o)
  );
endmodule

// File: tb/test_wdt_sticky_top.sv
`timescale 1ns/1ps
module test_wdt_sticky_top;
  logic       clk = 1'b0, slow_clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [7:0] rd_data;
  logic       nmi, sys_rst;

  int checks = 0, failures = 0;
  int tick = 0;
  int rst_rise_tick = 0, rst_rises = 0, hi_len = 0, last_len = 0;
  int nmi_rise_tick = 0, nmi_rises = 0;
  logic rst_prev = 1'b0, nmi_prev = 1'b0;
  logic [5:0] m_ctrl = 6'h00;
  bit done = 1'b0;

  always #2  clk = ~clk;
  always #23 slow_clk = ~slow_clk;

  wdt_sticky_top i_wdt_sticky_top (
    .clk_i(clk), .slow_clk_i(slow_clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .addr_i(addr), .wr_data_i(wdata),
    .rd_data_o(rd_data), .nmi_o(nmi), .sys_rst_o(sys_rst)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge slow_clk) tick++;

  always @(negedge slow_clk) begin
    if (sys_rst && !rst_prev) begin rst_rise_tick = tick; rst_rises++; end
    if (sys_rst) hi_len++;
    else if (rst_prev) begin last_len = hi_len; hi_len = 0; end
    rst_prev = sys_rst;
  end

  // reference for the control fields, compared every bus clock (R2, R3)
  always @(negedge clk) begin
    if (nmi && !nmi_prev) begin nmi_rise_tick = tick; nmi_rises++; end
    nmi_prev = nmi;
    if (rst_n && !done)
      chk({rd_data[5:4], rd_data[3], rd_data[2:0]} == m_ctrl, "R2/R3 ctrl", int'(rd_data[5:0]), int'(m_ctrl));
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    if (a == 8'h79) m_ctrl = {d[5:4], 1'b0, d[2:0]};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) @(posedge slow_clk);
    @(negedge clk);
  endtask

  task automatic wait_rst(input int base, input int max_ticks);
    for (int i = 0; i < max_ticks && rst_rises == base; i++) @(posedge slow_clk);
    @(negedge slow_clk);
    @(negedge clk);
  endtask

  initial begin
    #600000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int w, base, nbase;
    repeat (5) @(negedge clk);
    chk(rd_data == 8'h00 && !nmi && !sys_rst, "R1 in reset", int'({nmi, sys_rst, rd_data}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_data == 8'h00 && !nmi && !sys_rst, "R1 after reset", int'({nmi, sys_rst, rd_data}), 0);

    // R2: fields round-trip, strobe reads 0
    wr(8'h79, 8'h3D);
    chk(rd_data == 8'h35, "R2 readback", rd_data, 8'h35);
    wr(8'h79, 8'h00);
    // R3: foreign address ignored
    wr(8'h78, 8'h3F);
    chk(rd_data == 8'h00, "R3 foreign write", rd_data, 8'h00);

    // R4: keepalive with period 8
    wr(8'h79, 8'h28);
    for (int i = 0; i < 10; i++) begin
      wait_ticks(5);
      wr(8'h79, 8'h28);
    end
    chk(rst_rises == 0 && rd_data[7] == 1'b0, "R4 keepalive", rst_rises, 0);

    // R5: missed strobe, period 32
    wr(8'h79, 8'h2A);
    w = tick;
    wait_rst(0, 60);
    chk(rst_rises == 1, "R5 reset fired", rst_rises, 1);
    chk(rst_rise_tick - w >= 32 && rst_rise_tick - w <= 38, "R5 timeout window", rst_rise_tick - w, 32);
    wait_ticks(6);
    chk(last_len == 4, "R6 pulse length", last_len, 4);
    chk(rd_data == 8'hA2, "R7 sticky after pulse", rd_data, 8'hA2);
    wr(8'h79, 8'h02);
    chk(rd_data == 8'h82, "R8 write 0 keeps status", rd_data, 8'h82);
    wr(8'h79, 8'h82);
    chk(rd_data == 8'h02, "R8 write 1 clears status", rd_data, 8'h02);

    // R9: NMI only, period 8
    base = rst_rises;
    nbase = nmi_rises;
    wr(8'h79, 8'h18);
    w = tick;
    for (int i = 0; i < 40 && nmi_rises == nbase; i++) @(posedge slow_clk);
    @(negedge clk);
    chk(nmi == 1'b1 && rd_data[6] == 1'b1, "R9 nmi raised", int'({nmi, rd_data[6]}), 3);
    chk(nmi_rise_tick - w >= 8 && nmi_rise_tick - w <= 14, "R9 nmi window", nmi_rise_tick - w, 8);
    wait_ticks(10);
    chk(rst_rises == base && !sys_rst, "R9 no reset", rst_rises, base);
    wr(8'h79, 8'h00);
    wait_ticks(5);
    wr(8'h79, 8'h40);
    chk(rd_data == 8'h00 && !nmi, "R8 nmi status cleared", int'({nmi, rd_data}), 0);

    // R10: both enables, NMI then reset one period later
    base = rst_rises;
    nbase = nmi_rises;
    wr(8'h79, 8'h38);
    wait_rst(base, 60);
    chk(nmi_rises == nbase + 1, "R10 nmi first", nmi_rises, nbase + 1);
    chk(rst_rises == base + 1 && rst_rise_tick > nmi_rise_tick, "R10 reset after nmi", rst_rises, base + 1);
    chk(rst_rise_tick - nmi_rise_tick >= 7 && rst_rise_tick - nmi_rise_tick <= 9,
        "R10 gap", rst_rise_tick - nmi_rise_tick, 8);
    wr(8'h79, 8'h00);
    wait_ticks(8);
    chk(rd_data == 8'hC0, "R7 both status kept", rd_data, 8'hC0);
    wr(8'h79, 8'hC0);
    chk(rd_data == 8'h00, "R8 both cleared", rd_data, 8'h00);

    // R11: disabled, nothing expires
    base = rst_rises;
    nbase = nmi_rises;
    wait_ticks(40);
    chk(rst_rises == base && nmi_rises == nbase && !nmi && rd_data == 8'h00, "R11 idle",
        rst_rises + nmi_rises, base + nbase);

    // R12: period changes restart the count
    wr(8'h79, 8'h2A);
    for (int i = 0; i < 5; i++) begin
      wait_ticks(20);
      wr(8'h79, (i % 2 == 0) ? 8'h2B : 8'h2A);
    end
    w = tick;
    chk(rst_rises == base, "R12 no expiry while changing", rst_rises, base);
    wait_rst(base, 90);
    chk(rst_rises == base + 1 && rst_rise_tick - w >= 64 && rst_rise_tick - w <= 70,
        "R12 new period", rst_rise_tick - w, 64);
    wr(8'h79, 8'h03);
    wait_ticks(8);
    wr(8'h79, 8'h83);
    chk(rd_data == 8'h03, "R8 final clear", rd_data, 8'h03);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule